// File: doc/BRIEF.md
# External Memory Wait-State Controller

This block runs single accesses from a processor bus to external memory. The memory is split into four banks, a boot-ROM region and a multiprocessor memory-space region. A 32-bit configuration word gives each bank and the boot-ROM region its own 5-bit field. Each field holds a 2-bit acknowledge mode and a 3-bit wait code. The wait code picks an internal wait count. It also picks, from a fixed table that does not rise in step with the count, whether a hold-time cycle or a bus idle cycle follows the access.

A client raises `reqValid` with a region, direction, address and write data while `reqReady` is high. The controller then drives the read or write strobe. It ends the strobe phase from the internal wait count, from the external `ack` input, or from both, as the region's mode selects. It pulses `done` and captures read data. After that it adds the programmed trailing cycles before it accepts the next request.

Top module: `ext_wait_ctrl`

## Requirements
- R1: After reset, `cfgQ` reads 0x200D6B5A, `reqReady` is high, and both strobes, `done` and `busDataOe` are low.
- R2: A pulse on `cfgLoad` stores `cfgData` in the configuration register. Bits 31 and 28..25 always read zero, and bits 30, 29 and 24..0 take the written value.
- R3: Region r (r = 0..3 for the banks, r = 4 for boot ROM) reads its mode from `cfgQ[5r+1:5r]` and its wait code from `cfgQ[5r+4:5r+2]`. Any region code of 5 or above selects the multiprocessor region.
- R4: In mode 01 the strobe stays high for waits+1 clocks, and `ack` is ignored.
- R5: In mode 00 the strobe ends after the first strobe clock in which `ack` is sampled high. The strobe stays high indefinitely while `ack` stays low.
- R6: In mode 10 the strobe ends after the first strobe clock in which the wait count has expired and `ack` is high. With ack first high in strobe clock k, that is max(waits,k)+1 clocks.
- R7: In mode 11 the strobe ends on whichever comes first, so it lasts min(waits,k)+1 clocks.
- R8: Wait codes map to wait counts 0,1,2,3,4,5,6,0 for codes 000 through 111.
- R9: Codes 100 and 101 add one hold cycle after the strobe. In that cycle the strobe is low, while the address and the write data stay unchanged and driven (`busDataOe` high for writes).
- R10: Codes 001, 010, 011, 110 and 111 add one idle cycle after the strobe, with `busDataOe` low. Code 000 adds neither cycle. Both additions apply in every acknowledge mode.
- R11: `done` is high for exactly the one clock that follows the last strobe clock. `rdData` then holds `busDataIn` as sampled at the edge that ends a read strobe.
- R12: A request is accepted only while `reqReady` is high, and its strobe begins in the next clock. `reqReady` stays low until the hold and idle cycles are over, and only one strobe is ever high.
- R13: An access to the multiprocessor region uses internal-count mode with one wait state when bit 30 is set and none when it is clear. It adds no hold cycle and no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Loads the configuration word |
| cfgData | input | 32 | Configuration word to load |
| cfgQ | output | 32 | Current configuration word |
| reqValid | input | 1 | Access request |
| reqRegion | input | 3 | Region select (0-3 banks, 4 boot ROM, 5+ multiprocessor) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access address |
| reqData | input | DATA_W | Write data |
| reqReady | output | 1 | Controller idle, can accept a request |
| done | output | 1 | One-clock pulse at the end of the strobe phase |
| rdData | output | DATA_W | Captured read data |
| ack | input | 1 | External acknowledge |
| busAddr | output | ADDR_W | External address |
| busDataOut | output | DATA_W | External write data |
| busDataOe | output | 1 | Write data output enable |
| busDataIn | input | DATA_W | External read data |
| strobeRd | output | 1 | Read strobe, active high |
| strobeWr | output | 1 | Write strobe, active high |

## Verification
The bench builds the block with its defaults: a 16-bit address, a 32-bit data path and the 0x200D6B5A reset word. The reset word's bank-0 field (mode 10, six waits, idle) lets the bench test a wait-and-ACK access before any load. The 32-bit data width makes a fresh random read value possible on every strobe clock, so a capture one edge early or late shows up at once. The short 3-bit wait field keeps every strobe under a few dozen clocks. Directed runs therefore fit next to a long run of random configurations, and a delayed ACK of 20 clocks in ACK-only mode still fits.

// File: rtl/ext_wait_pkg.sv
package ext_wait_pkg;

  localparam int CFG_W      = 32;
  localparam int FIELD_W    = 5;
  localparam int NUM_FIELDS = 5;   // four banks plus boot ROM
  localparam int REGION_W   = 3;
  localparam int CNT_W      = 3;
  localparam int MP_WAIT_BIT = 30;
  localparam logic [CFG_W-1:0] CFG_KEEP_MASK = 32'h61FF_FFFF;

  typedef enum logic [1:0] {
    ACK_ONLY   = 2'b00,
    COUNT_ONLY = 2'b01,
    BOTH_REQ   = 2'b10,
    EITHER_END = 2'b11
  } ackMode_e;

  typedef struct packed {
    ackMode_e         mode;
    logic [CNT_W-1:0] waits;
    logic             hold;
    logic             idle;
  } accessCfg_t;

  typedef struct packed {
    logic latch;
    logic strobeOn;
    logic driveOn;
    logic capture;
  } dpCtrl_t;

  function automatic accessCfg_t decodeField(input logic [FIELD_W-1:0] field);
    accessCfg_t c;
    c.mode = ackMode_e'(field[1:0]);
    c.hold = 1'b0;
    c.idle = 1'b0;
    unique case (field[4:2])
      3'd0: c.waits = 3'd0;
      3'd1, 3'd2, 3'd3: begin c.waits = field[4:2]; c.idle = 1'b1; end
      3'd4, 3'd5:       begin c.waits = field[4:2]; c.hold = 1'b1; end
      3'd6: begin c.waits = 3'd6; c.idle = 1'b1; end
      default: begin c.waits = 3'd0; c.idle = 1'b1; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ext_wait_datapath.sv
module ext_wait_datapath
  import ext_wait_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [CFG_W-1:0] RESET_CFG = 32'h200D_6B5A
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoad,
  input  logic [CFG_W-1:0]    cfgData,
  output logic [CFG_W-1:0]    cfgQ,
  input  logic [REGION_W-1:0] reqRegion,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  dpCtrl_t             ctrl,
  output accessCfg_t          accQ,
  input  logic [DATA_W-1:0]   busDataIn,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   busDataOut,
  output logic                busDataOe,
  output logic                strobeRd,
  output logic                strobeWr,
  output logic [DATA_W-1:0]   rdData
);

  logic [CFG_W-1:0] cfgReg;
  accessCfg_t       fieldCfg [NUM_FIELDS];
  accessCfg_t       mpCfg;
  accessCfg_t       selCfg;
  logic             wrQ;

  always_ff @(posedge clk) begin
    if (!rstN)        cfgReg <= RESET_CFG & CFG_KEEP_MASK;
    else if (cfgLoad) cfgReg <= cfgData & CFG_KEEP_MASK;
  end
  assign cfgQ = cfgReg;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign fieldCfg[g] = decodeField(cfgReg[FIELD_W*g +: FIELD_W]);
  end

  always_comb begin
    mpCfg.mode  = COUNT_ONLY;
    mpCfg.waits = {{(CNT_W-1){1'b0}}, cfgReg[MP_WAIT_BIT]};
    mpCfg.hold  = 1'b0;
    mpCfg.idle  = 1'b0;
  end

  always_comb begin
    selCfg = mpCfg;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (reqRegion == REGION_W'(i)) selCfg = fieldCfg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ       <= '0;
      wrQ        <= 1'b0;
      busAddr    <= '0;
      busDataOut <= '0;
      rdData     <= '0;
    end else begin
      if (ctrl.latch) begin
        accQ       <= selCfg;
        wrQ        <= reqWrite;
        busAddr    <= reqAddr;
        busDataOut <= reqData;
      end
      if (ctrl.capture && !wrQ) rdData <= busDataIn;
    end
  end

  assign busDataOe = ctrl.driveOn & wrQ;
  assign strobeWr  = ctrl.strobeOn & wrQ;
  assign strobeRd  = ctrl.strobeOn & ~wrQ;

endmodule

// File: rtl/ext_wait_fsm.sv
module ext_wait_fsm
  import ext_wait_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       ack,
  input  accessCfg_t accQ,
  output dpCtrl_t    ctrl,
  output logic       reqReady,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_HOLD, S_GAP} state_e;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  state_e           state, nextState;
  logic [CNT_W-1:0] cnt;
  logic             countDone;
  logic             endNow;

  assign countDone = (cnt >= accQ.waits);

  always_comb begin
    ctrl      = '0;
    nextState = state;
    endNow    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          ctrl.latch = 1'b1;
          nextState  = S_STROBE;
        end
      end
      S_STROBE: begin
        ctrl.strobeOn = 1'b1;
        ctrl.driveOn  = 1'b1;
        unique case (accQ.mode)
          ACK_ONLY:   endNow = ack;
          COUNT_ONLY: endNow = countDone;
          BOTH_REQ:   endNow = countDone && ack;
          default:    endNow = countDone || ack;
        endcase
        if (endNow) begin
          ctrl.capture = 1'b1;
          if (accQ.hold)      nextState = S_HOLD;
          else if (accQ.idle) nextState = S_GAP;
          else                nextState = S_IDLE;
        end
      end
      S_HOLD: begin
        ctrl.driveOn = 1'b1;
        nextState    = accQ.idle ? S_GAP : S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= endNow;
      if (ctrl.latch)
        cnt <= '0;
      else if (state == S_STROBE && !endNow && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end

  assign reqReady = (state == S_IDLE);

endmodule

// File: rtl/ext_wait_ctrl.sv
module ext_wait_ctrl
  import ext_wait_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [31:0] RESET_CFG = 32'h200D_6B5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [31:0]       cfgData,
  output logic [31:0]       cfgQ,
  input  logic              reqValid,
  input  logic [2:0]        reqRegion,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  input  logic              ack,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              strobeRd,
  output logic              strobeWr
);

  dpCtrl_t    ctrl;
  accessCfg_t accQ;

  ext_wait_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ack      (ack),
    .accQ     (accQ),
    .ctrl     (ctrl),
    .reqReady (reqReady),
    .done     (done)
  );

  ext_wait_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RESET_CFG (RESET_CFG)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgLoad    (cfgLoad),
    .cfgData    (cfgData),
    .cfgQ       (cfgQ),
    .reqRegion  (reqRegion),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .ctrl       (ctrl),
    .accQ       (accQ),
    .busDataIn  (busDataIn),
    .busAddr    (busAddr),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe),
    .strobeRd   (strobeRd),
    .strobeWr   (strobeWr),
    .rdData     (rdData)
  );

endmodule

// File: rtl/ext_wait_ctrl_checker.sv
module ext_wait_ctrl_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgLoad,
  input logic [31:0]       cfgQ,
  input logic              reqReady,
  input logic              done,
  input logic [ADDR_W-1:0] busAddr,
  input logic              strobeRd,
  input logic              strobeWr
);

  logic anyStrobe;
  assign anyStrobe = strobeRd | strobeWr;

  p_reserved_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> (cfgQ[28:25] == 4'd0 && !cfgQ[31]));

  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> $stable(busAddr));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!anyStrobe && $past(anyStrobe)));

  p_no_strobe_when_ready_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !anyStrobe);

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(strobeRd && strobeWr));

endmodule

bind ext_wait_ctrl ext_wait_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgLoad  (cfgLoad),
  .cfgQ     (cfgQ),
  .reqReady (reqReady),
  .done     (done),
  .busAddr  (busAddr),
  .strobeRd (strobeRd),
  .strobeWr (strobeWr)
);

// File: tb/ext_wait_ctrl_tb.sv
module ext_wait_ctrl_tb;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [31:0] cfgData = '0;
  logic [31:0] cfgQ;
  logic reqValid = 1'b0;
  logic [2:0] reqRegion = '0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic reqReady, done;
  logic [DATA_W-1:0] rdData;
  logic ack = 1'b0;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busDataOut;
  logic busDataOe;
  logic [DATA_W-1:0] busDataIn = '0;
  logic strobeRd, strobeWr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] cfgShadow = 32'h200D_6B5A;

  always #10 clk = ~clk;  // 50 MHz

  ext_wait_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgData(cfgData), .cfgQ(cfgQ),
    .reqValid(reqValid), .reqRegion(reqRegion), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady), .done(done),
    .rdData(rdData), .ack(ack), .busAddr(busAddr), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn), .strobeRd(strobeRd),
    .strobeWr(strobeWr)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // R8: wait-code table; R9/R10: trailing cycles
  function automatic int codeWaits(input int code);
    return (code == 7) ? 0 : code;
  endfunction

  // R3 field positions, R13 multiprocessor region
  task automatic expParams(input int region, output int mode, output int waits,
                           output bit hold, output bit idle);
    int code;
    if (region >= 5) begin
      mode = 1; waits = cfgShadow[30] ? 1 : 0; hold = 0; idle = 0;
    end else begin
      mode = (cfgShadow >> (5 * region)) & 3;
      code = (cfgShadow >> (5 * region + 2)) & 7;
      waits = codeWaits(code);
      hold = (code == 4 || code == 5);
      idle = (code != 0 && !hold);
    end
  endtask

  function automatic int expLen(input int mode, input int waits, input int k);
    case (mode)
      0: return k + 1;
      1: return waits + 1;
      2: return ((waits > k) ? waits : k) + 1;
      default: return ((waits < k) ? waits : k) + 1;
    endcase
  endfunction

  function automatic string modeTag(input int region, input int mode);
    if (region >= 5) return "R13";
    case (mode)
      0: return "R5/R8";
      1: return "R4/R8";
      2: return "R6/R8";
      default: return "R7/R8";
    endcase
  endfunction

  task automatic loadCfg(input logic [31:0] v);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    cfgData = v; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    cfgShadow = v & 32'h61FF_FFFF;
  endtask

  task automatic runAccess(input int region, input bit wr, input int ackDelay);
    int mode, waits, expL, strobeLen, holdN, idleN, bad;
    bit hold, idle;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d, lastIn;
    expParams(region, mode, waits, hold, idle);
    expL = expLen(mode, waits, ackDelay);
    a = ADDR_W'($urandom);
    d = DATA_W'($urandom);
    lastIn = '0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqRegion = 3'(region); reqWrite = wr; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    check("R12 strobe starts next clock", (wr ? strobeWr : strobeRd) && !reqReady,
          {strobeWr, strobeRd, reqReady}, wr ? 4 : 2);
    strobeLen = 0; bad = 0;
    while ((strobeRd || strobeWr) && strobeLen < 64) begin
      if (reqReady || done || (wr ? strobeRd : strobeWr)) bad++;
      if (busAddr != a) bad++;
      ack = (strobeLen >= ackDelay);
      lastIn = DATA_W'($urandom);
      busDataIn = lastIn;
      strobeLen++;
      @(negedge clk);
    end
    ack = 1'b0;
    check("R12 busy during strobe", bad == 0, bad, 0);
    check(modeTag(region, mode), strobeLen == expL, strobeLen, expL);
    check("R11 done pulse", done == 1'b1, done, 1);
    if (!wr) check("R11 read capture", rdData == lastIn, rdData, lastIn);
    holdN = 0; idleN = 0; bad = 0;
    while (!reqReady && holdN + idleN < 8) begin
      if (busAddr != a || strobeRd || strobeWr) bad++;
      if (wr && busDataOe && busDataOut != d) bad++;
      if (busDataOe) holdN++; else idleN++;
      @(negedge clk);
    end
    check("R9 held address/data", bad == 0, bad, 0);
    if (wr) begin
      check("R9 hold cycles", holdN == int'(hold), holdN, hold);
      check("R10 idle cycles", idleN == int'(idle), idleN, idle);
    end else begin
      check("R9/R10 trailing cycles", holdN + idleN == int'(hold) + int'(idle),
            holdN + idleN, int'(hold) + int'(idle));
    end
  endtask

  initial begin
    logic [31:0] dirCfg;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg", cfgQ == 32'h200D_6B5A, cfgQ, 32'h200D_6B5A);
    check("R1 idle outputs", reqReady && !strobeRd && !strobeWr && !done && !busDataOe,
          {reqReady, strobeRd, strobeWr, done, busDataOe}, 5'b10000);

    // reset word, bank 0: mode 10, 6 waits, idle (R3, R6)
    runAccess(0, 1'b1, 0);
    runAccess(0, 1'b0, 9);

    // R2 reserved bits
    loadCfg(32'hFFFF_FFFF);
    check("R2 reserved bits", cfgQ == 32'h61FF_FFFF, cfgQ, 32'h61FF_FFFF);

    // directed field set (R3): bank0 00/000, bank1 01/100, bank2 11/111,
    // bank3 10/101, boot 01/001, multiprocessor wait on
    dirCfg = (32'h00 << 0) | (32'h11 << 5) | (32'h1F << 10) | (32'h16 << 15)
           | (32'h05 << 20) | (32'h1 << 30);
    loadCfg(dirCfg);
    check("R2 load", cfgQ == dirCfg, cfgQ, dirCfg);
    runAccess(0, 1'b0, 20);  // R5 long wait for ack
    runAccess(0, 1'b1, 0);   // R10 code 000: no trailing cycle
    runAccess(1, 1'b1, 0);   // R4 ack ignored, R9 hold
    runAccess(2, 1'b1, 3);   // R7 code 111: zero waits, idle
    runAccess(3, 1'b1, 2);   // R6 count later than ack, hold in mode 10
    runAccess(3, 1'b0, 8);   // R6 ack later than count
    runAccess(4, 1'b0, 0);   // R3 boot region
    runAccess(5, 1'b1, 0);   // R13 one wait
    loadCfg(dirCfg & ~(32'h1 << 30));
    runAccess(7, 1'b0, 4);   // R13 no wait

    // random configurations and accesses
    for (int n = 0; n < 80; n++) begin
      if (n % 10 == 0) loadCfg($urandom);
      runAccess($urandom_range(0, 7), 1'($urandom), $urandom_range(0, 7));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule